// File: doc/BRIEF.md
# Ranging Acquisition and Tracking Sequencer

This block is the control state machine of a tone-and-code ranging receiver. After reset it steers the carrier-tone loop's frequency command through a stepped sweep until the loop reports lock. It then walks the ambiguity-resolving components one at a time, lowest index first, and moves to tracking once the last one has locked. It picks a loop bandwidth code for each phase and restarts acquisition by itself when lock drops. The restart is seeded with the last locked tone frequency and the last valid range.

A 32-bit range value from the phase-measurement datapath is latched on each rising edge of the timing pulse. It is flagged valid only while the receiver is in full code lock. Lock indicators are judged only on check-interval strobes (`chk_tick`), so the debounce windows count intervals rather than clock cycles. Every port is a plain level or a single-cycle strobe. There is no streaming data path, so no valid/ready handshake and no back-pressure applies. All configuration inputs are expected to stay steady while the sequencer uses them.

Top module: `rng_acq_seq`

## Requirements
- R1: The sweep starts at centre minus `cfg_half_span`. It holds each frequency for `cfg_dwell` cycles in the search state (0 counts as 1), then adds `cfg_step`. When the next point would pass centre plus `cfg_half_span`, it wraps back to the low edge instead.
- R2: The sweep centre is `cfg_nominal + dop_offset` (modulo 2^FW) if `dop_valid` is high in the cycle after reset ends, and `cfg_nominal` otherwise.
- R3: `search_fail` is set on every sweep wrap and stays set until `fail_clr` is pulsed. A wrap in the same cycle as `fail_clr` wins.
- R4: The tone counts as locked only after `tone_lock` is high on `cfg_lock_n` consecutive check ticks (0 counts as 1). A tick with `tone_lock` low restarts the count. On lock, `freq_cmd` freezes at the value it held on the qualifying cycle.
- R5: Components are resolved in index order 0, 1, … NCOMP-1 on `comp_idx`. Each needs `comp_lock` high on `cfg_lock_n` consecutive ticks. After the last one, the sequencer enters tracking.
- R6: On entry to resolution, if `rng_aid_valid` is high or a tracked range exists, `rng_preload` pulses for one cycle. `rng_preload_val` carries `rng_aid` (this takes priority) or else the last valid range. Each component of such an aided pass needs only one locked tick.
- R7: With `cfg_auto_bw` low, `bw_sel` equals `cfg_bw_acq` in reset, search and resolution, and `cfg_bw_trk` in tracking.
- R8: With `cfg_auto_bw` high, the tracking code is 0 when `snr_meas >= cfg_snr_hi`, 1 when `snr_meas >= cfg_snr_lo`, and 2 otherwise. The acquisition code is the tracking code plus 1.
- R9: In tracking, if `tone_lock & comp_lock` is low on `cfg_loss_m` consecutive ticks, the sequencer returns to search. The new sweep is centred on the last locked frequency, and `alarm_loss` stays set until tracking is reached again.
- R10: A rising edge of `timing_pulse` latches `range_in` into `range_word`. A held-high pulse does not latch again. `range_valid` is 1 only when the latch was taken in tracking, and it drops once tracking is left.
- R11: `st_tone_lock` is 1 in resolution and tracking, `st_code_lock` is 1 in tracking, and `st_acq` is 1 outside tracking. `st_odd_even` flips each time a loss of lock starts a new attempt.
- R12: During reset, `freq_cmd`, `comp_idx`, `range_word`, `range_valid`, `rng_preload`, `st_tone_lock`, `st_code_lock`, `st_odd_even`, `alarm_loss` and `search_fail` are 0, `st_acq` is 1, and `bw_sel` follows the acquisition code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nominal | input | FW | Nominal tone frequency command |
| cfg_half_span | input | FW | Half width of the sweep |
| cfg_step | input | FW | Sweep step size |
| cfg_dwell | input | DW | Cycles per sweep point |
| cfg_lock_n | input | QW | Consecutive locked ticks needed |
| cfg_loss_m | input | QW | Consecutive unlocked ticks to declare loss |
| cfg_bw_acq | input | BW | Manual acquisition bandwidth code |
| cfg_bw_trk | input | BW | Manual tracking bandwidth code |
| cfg_auto_bw | input | 1 | Select bandwidth from SNR |
| cfg_snr_lo | input | SW | Lower SNR threshold |
| cfg_snr_hi | input | SW | Upper SNR threshold |
| snr_meas | input | SW | Measured signal-to-noise figure |
| dop_valid | input | 1 | Doppler aid present |
| dop_offset | input | FW | Doppler offset (two's complement) |
| rng_aid_valid | input | 1 | Range aid present |
| rng_aid | input | RW | Range aid value |
| chk_tick | input | 1 | Lock check interval strobe |
| tone_lock | input | 1 | Tone loop lock indicator |
| comp_lock | input | 1 | Current component lock indicator |
| timing_pulse | input | 1 | Range latch timing pulse |
| range_in | input | RW | Range from measurement datapath |
| fail_clr | input | 1 | Clear sticky search failure |
| freq_cmd | output | FW | Tone-loop NCO frequency command |
| bw_sel | output | BW | Loop bandwidth code |
| comp_idx | output | CIW | Component being resolved |
| rng_preload | output | 1 | One-cycle preload strobe |
| rng_preload_val | output | RW | Preload range value |
| range_word | output | RW | Latched range |
| range_valid | output | 1 | Latched range taken in full lock |
| st_tone_lock | output | 1 | Tone locked |
| st_code_lock | output | 1 | All components locked |
| st_acq | output | 1 | Acquisition in progress |
| st_odd_even | output | 1 | Attempt parity |
| alarm_loss | output | 1 | Lock lost, not yet regained |
| search_fail | output | 1 | Sticky sweep failure |

## Verification
A wrong state register shows up within one clock at the status pins and at `bw_sel`, because both decode the state directly. A corrupted sweep counter or dwell counter is caught within one dwell period, since the bench compares `freq_cmd` against the expected staircase on every cycle. A debounce counter that is off by one moves the lock or loss transition by a single tick. The bench pins that transition to an exact clock edge, so the error is seen there. Bad seed storage only becomes visible on the next reacquisition, as a wrong sweep start or a wrong preload value.

// File: rtl/rng_acq_pkg.sv
package rng_acq_pkg;
  typedef enum logic [1:0] {
    ST_INIT    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_RESOLVE = 2'd2,
    ST_TRACK   = 2'd3
  } acq_state_e;
endpackage

// File: rtl/rng_lock_qual.sv
// Counts consecutive check ticks on which in_sig is high; hit flags the
// tick that completes the required run.
module rng_lock_qual #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          in_sig,
  input  logic [QW-1:0] thr,
  output logic          hit
);
  logic [QW-1:0] cnt;
  logic [QW:0]   thr_eff;
  logic [QW:0]   run_next;

  assign thr_eff  = (thr == '0) ? (QW+1)'(1) : {1'b0, thr};
  assign run_next = {1'b0, cnt} + (QW+1)'(1);
  assign hit      = tick && in_sig && (run_next >= thr_eff);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (!in_sig)       cnt <= '0;
      else if (~&cnt)    cnt <= cnt + QW'(1);
    end
  end

  // R4/R5: a run longer than one tick needs earlier counted ticks
  a_r4_run_before_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && thr_eff > (QW+1)'(1)) |-> (cnt != '0));
endmodule

// File: rtl/rng_sweep.sv
// Stepped frequency sweep around a loaded centre, wrapping at the span edge.
module rng_sweep #(
  parameter int FW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] center,
  input  logic [FW-1:0] half_span,
  input  logic [FW-1:0] step,
  input  logic [DW-1:0] dwell,
  input  logic          en,
  output logic [FW-1:0] freq,
  output logic          wrap
);
  logic [FW-1:0] lo_edge;
  logic [FW-1:0] pos;
  logic [DW-1:0] dcnt;
  logic [DW-1:0] dwell_last;
  logic          dwell_done;
  logic [FW:0]   pos_next;

  assign dwell_last = (dwell == '0) ? '0 : dwell - DW'(1);
  assign dwell_done = (dcnt >= dwell_last);
  assign pos_next   = {1'b0, pos} + {1'b0, step};
  assign wrap       = en && !load && dwell_done && (pos_next > {half_span, 1'b0});
  assign freq       = lo_edge + pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_edge <= '0;
      pos     <= '0;
      dcnt    <= '0;
    end else if (load) begin
      lo_edge <= center - half_span;
      pos     <= '0;
      dcnt    <= '0;
    end else if (en) begin
      if (dwell_done) begin
        dcnt <= '0;
        pos  <= wrap ? '0 : pos_next[FW-1:0];
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end
  end

  // R1: frequency stays put inside a dwell
  a_r1_hold_in_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !dwell_done) |=> $stable(freq));
endmodule

// File: rtl/rng_bw_pick.sv
// Loop bandwidth code selection: manual per phase, or graded by SNR.
module rng_bw_pick #(
  parameter int SW = 8,
  parameter int BW = 3
) (
  input  logic          auto_en,
  input  logic          tracking,
  input  logic [SW-1:0] snr,
  input  logic [SW-1:0] snr_lo,
  input  logic [SW-1:0] snr_hi,
  input  logic [BW-1:0] code_acq,
  input  logic [BW-1:0] code_trk,
  output logic [BW-1:0] bw_sel
);
  logic [BW-1:0] graded;

  always_comb begin
    if (snr >= snr_hi)      graded = BW'(0);
    else if (snr >= snr_lo) graded = BW'(1);
    else                    graded = BW'(2);
    if (auto_en) bw_sel = tracking ? graded : graded + BW'(1);
    else         bw_sel = tracking ? code_trk : code_acq;
  end
endmodule

// File: rtl/rng_acq_seq.sv
module rng_acq_seq
  import rng_acq_pkg::*;
#(
  parameter int FW    = 24,
  parameter int DW    = 16,
  parameter int QW    = 4,
  parameter int SW    = 8,
  parameter int BW    = 3,
  parameter int RW    = 32,
  parameter int NCOMP = 4,
  localparam int CIW  = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] cfg_nominal,
  input  logic [FW-1:0] cfg_half_span,
  input  logic [FW-1:0] cfg_step,
  input  logic [DW-1:0] cfg_dwell,
  input  logic [QW-1:0] cfg_lock_n,
  input  logic [QW-1:0] cfg_loss_m,
  input  logic [BW-1:0] cfg_bw_acq,
  input  logic [BW-1:0] cfg_bw_trk,
  input  logic          cfg_auto_bw,
  input  logic [SW-1:0] cfg_snr_lo,
  input  logic [SW-1:0] cfg_snr_hi,
  input  logic [SW-1:0] snr_meas,
  input  logic          dop_valid,
  input  logic [FW-1:0] dop_offset,
  input  logic          rng_aid_valid,
  input  logic [RW-1:0] rng_aid,
  input  logic          chk_tick,
  input  logic          tone_lock,
  input  logic          comp_lock,
  input  logic          timing_pulse,
  input  logic [RW-1:0] range_in,
  input  logic          fail_clr,
  output logic [FW-1:0] freq_cmd,
  output logic [BW-1:0] bw_sel,
  output logic [CIW-1:0] comp_idx,
  output logic          rng_preload,
  output logic [RW-1:0] rng_preload_val,
  output logic [RW-1:0] range_word,
  output logic          range_valid,
  output logic          st_tone_lock,
  output logic          st_code_lock,
  output logic          st_acq,
  output logic          st_odd_even,
  output logic          alarm_loss,
  output logic          search_fail
);
  localparam logic [CIW-1:0] LAST_IDX = CIW'(NCOMP - 1);

  acq_state_e    state, state_nxt;
  logic [FW-1:0] sweep_freq, sweep_center, last_freq;
  logic [RW-1:0] last_range;
  logic          sweep_load, sweep_wrap, seed_ok, aided, tp_q, tp_rise;
  logic          tone_hit, comp_hit, loss_hit, comp_clr;
  logic [QW-1:0] comp_thr;

  // ---- qualifiers ---------------------------------------------------------
  assign comp_thr = aided ? QW'(1) : cfg_lock_n;
  assign comp_clr = (state != ST_RESOLVE) || comp_hit;

  rng_lock_qual #(.QW(QW)) u_tone_q (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_SEARCH), .tick(chk_tick),
    .in_sig(tone_lock), .thr(cfg_lock_n), .hit(tone_hit));

  rng_lock_qual #(.QW(QW)) u_comp_q (
    .clk(clk), .rst_n(rst_n), .clr(comp_clr), .tick(chk_tick),
    .in_sig(comp_lock), .thr(comp_thr), .hit(comp_hit));

  rng_lock_qual #(.QW(QW)) u_loss_q (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_TRACK), .tick(chk_tick),
    .in_sig(!(tone_lock && comp_lock)), .thr(cfg_loss_m), .hit(loss_hit));

  // ---- sweep --------------------------------------------------------------
  rng_sweep #(.FW(FW), .DW(DW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .load(sweep_load), .center(sweep_center),
    .half_span(cfg_half_span), .step(cfg_step), .dwell(cfg_dwell),
    .en(state == ST_SEARCH), .freq(sweep_freq), .wrap(sweep_wrap));

  // ---- sequencing ---------------------------------------------------------
  always_comb begin
    state_nxt    = state;
    sweep_load   = 1'b0;
    sweep_center = dop_valid ? cfg_nominal + dop_offset : cfg_nominal;
    unique case (state)
      ST_INIT: begin
        state_nxt  = ST_SEARCH;
        sweep_load = 1'b1;
      end
      ST_SEARCH:  if (tone_hit) state_nxt = ST_RESOLVE;
      ST_RESOLVE: if (comp_hit && comp_idx == LAST_IDX) state_nxt = ST_TRACK;
      ST_TRACK: begin
        sweep_center = last_freq;
        if (loss_hit) begin
          state_nxt  = ST_SEARCH;
          sweep_load = 1'b1;
        end
      end
      default: state_nxt = ST_INIT;
    endcase
  end

  assign tp_rise = timing_pulse && !tp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= ST_INIT;
      comp_idx        <= '0;
      last_freq       <= '0;
      last_range      <= '0;
      seed_ok         <= 1'b0;
      aided           <= 1'b0;
      rng_preload     <= 1'b0;
      rng_preload_val <= '0;
      st_odd_even     <= 1'b0;
      alarm_loss      <= 1'b0;
      search_fail     <= 1'b0;
      tp_q            <= 1'b0;
      range_word      <= '0;
      range_valid     <= 1'b0;
    end else begin
      state       <= state_nxt;
      tp_q        <= timing_pulse;
      rng_preload <= 1'b0;

      if (sweep_wrap)    search_fail <= 1'b1;
      else if (fail_clr) search_fail <= 1'b0;

      if (state == ST_SEARCH && tone_hit) begin
        last_freq       <= sweep_freq;
        comp_idx        <= '0;
        aided           <= rng_aid_valid || seed_ok;
        rng_preload     <= rng_aid_valid || seed_ok;
        rng_preload_val <= rng_aid_valid ? rng_aid : last_range;
      end

      if (state == ST_RESOLVE && comp_hit && comp_idx != LAST_IDX)
        comp_idx <= comp_idx + CIW'(1);

      if (state == ST_TRACK && loss_hit) begin
        alarm_loss  <= 1'b1;
        st_odd_even <= ~st_odd_even;
      end else if (state_nxt == ST_TRACK) begin
        alarm_loss  <= 1'b0;
      end

      if (tp_rise) begin
        range_word  <= range_in;
        range_valid <= (state_nxt == ST_TRACK);
        if (state == ST_TRACK) begin
          last_range <= range_in;
          seed_ok    <= 1'b1;
        end
      end else if (state_nxt != ST_TRACK) begin
        range_valid <= 1'b0;
      end
    end
  end

  // ---- outputs ------------------------------------------------------------
  assign freq_cmd     = (state == ST_SEARCH) ? sweep_freq : last_freq;
  assign st_tone_lock = (state == ST_RESOLVE) || (state == ST_TRACK);
  assign st_code_lock = (state == ST_TRACK);
  assign st_acq       = (state != ST_TRACK);

  rng_bw_pick #(.SW(SW), .BW(BW)) u_bw (
    .auto_en(cfg_auto_bw), .tracking(state == ST_TRACK), .snr(snr_meas),
    .snr_lo(cfg_snr_lo), .snr_hi(cfg_snr_hi), .code_acq(cfg_bw_acq),
    .code_trk(cfg_bw_trk), .bw_sel(bw_sel));

  // ---- assertions ---------------------------------------------------------
  a_r10_valid_in_track: assert property (@(posedge clk) disable iff (!rst_n)
    range_valid |-> st_code_lock);

  a_r4_freq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESOLVE && $past(state == ST_RESOLVE)) |-> $stable(freq_cmd));

  a_r11_parity_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_odd_even != $past(st_odd_even)) |-> ($past(state == ST_TRACK) && state == ST_SEARCH));

  a_r3_fail_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_fail) |-> $past(sweep_wrap));

  a_r5_idx_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESOLVE && $past(state == ST_RESOLVE) && comp_idx != $past(comp_idx))
      |-> (comp_idx == $past(comp_idx) + CIW'(1)));

  a_r6_preload_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rng_preload |-> (state == ST_RESOLVE && $past(state == ST_SEARCH)));
endmodule

// File: tb/test_rng_acq_seq.sv
`timescale 1ns/1ps
module test_rng_acq_seq;
  localparam int FW = 16, DW = 16, QW = 4, SW = 8, BW = 3, RW = 32, NCOMP = 3;
  localparam int CIW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [FW-1:0] cfg_nominal, cfg_half_span, cfg_step, dop_offset;
  logic [DW-1:0] cfg_dwell;
  logic [QW-1:0] cfg_lock_n, cfg_loss_m;
  logic [BW-1:0] cfg_bw_acq, cfg_bw_trk;
  logic          cfg_auto_bw;
  logic [SW-1:0] cfg_snr_lo, cfg_snr_hi, snr_meas;
  logic          dop_valid, rng_aid_valid, chk_tick, tone_lock, comp_lock;
  logic          timing_pulse, fail_clr;
  logic [RW-1:0] rng_aid, range_in;
  logic [FW-1:0] freq_cmd;
  logic [BW-1:0] bw_sel;
  logic [CIW-1:0] comp_idx;
  logic          rng_preload, range_valid, st_tone_lock, st_code_lock, st_acq;
  logic          st_odd_even, alarm_loss, search_fail;
  logic [RW-1:0] rng_preload_val, range_word;

  rng_acq_seq #(.FW(FW), .DW(DW), .QW(QW), .SW(SW), .BW(BW), .RW(RW), .NCOMP(NCOMP))
  i_rng_acq_seq (
    .clk(clk), .rst_n(rst_n), .cfg_nominal(cfg_nominal), .cfg_half_span(cfg_half_span),
    .cfg_step(cfg_step), .cfg_dwell(cfg_dwell), .cfg_lock_n(cfg_lock_n),
    .cfg_loss_m(cfg_loss_m), .cfg_bw_acq(cfg_bw_acq), .cfg_bw_trk(cfg_bw_trk),
    .cfg_auto_bw(cfg_auto_bw), .cfg_snr_lo(cfg_snr_lo), .cfg_snr_hi(cfg_snr_hi),
    .snr_meas(snr_meas), .dop_valid(dop_valid), .dop_offset(dop_offset),
    .rng_aid_valid(rng_aid_valid), .rng_aid(rng_aid), .chk_tick(chk_tick),
    .tone_lock(tone_lock), .comp_lock(comp_lock), .timing_pulse(timing_pulse),
    .range_in(range_in), .fail_clr(fail_clr), .freq_cmd(freq_cmd), .bw_sel(bw_sel),
    .comp_idx(comp_idx), .rng_preload(rng_preload), .rng_preload_val(rng_preload_val),
    .range_word(range_word), .range_valid(range_valid), .st_tone_lock(st_tone_lock),
    .st_code_lock(st_code_lock), .st_acq(st_acq), .st_odd_even(st_odd_even),
    .alarm_loss(alarm_loss), .search_fail(search_fail));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [FW-1:0] held_f;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // leaves the bench at the sample just after the first post-reset edge
  task automatic do_reset(input bit dv, input logic [FW-1:0] doff,
                          input bit av, input logic [RW-1:0] aval);
    @(negedge clk);
    rst_n = 0;
    cfg_nominal = 1000; cfg_half_span = 20; cfg_step = 10; cfg_dwell = 3;
    cfg_lock_n = 3; cfg_loss_m = 2; cfg_bw_acq = 5; cfg_bw_trk = 2;
    cfg_auto_bw = 0; cfg_snr_lo = 10; cfg_snr_hi = 20; snr_meas = 0;
    dop_valid = dv; dop_offset = doff; rng_aid_valid = av; rng_aid = aval;
    chk_tick = 1; tone_lock = 0; comp_lock = 0; timing_pulse = 0;
    range_in = 0; fail_clr = 0;
    step_n(3);
    rst_n = 1;
    step_n(1);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 0;
    step_n(2);
    chk(freq_cmd == 0 && comp_idx == 0 && range_word == 0, "R12 zero data", freq_cmd, 0);
    chk(!range_valid && !rng_preload && !st_tone_lock && !st_code_lock, "R12 flags", range_valid, 0);
    chk(!st_odd_even && !alarm_loss && !search_fail && st_acq, "R12 status", st_acq, 1);
    chk(bw_sel == cfg_bw_acq, "R12 bw", bw_sel, cfg_bw_acq);
  endtask

  task automatic t_sweep_plain;
    do_reset(0, 0, 0, 0);
    for (int k = 0; k < 16; k++) begin
      logic [FW-1:0] e;
      e = FW'(980 + 10 * ((k / 3) % 5));
      chk(freq_cmd == e, "R1 sweep point", freq_cmd, e);
      if (k == 14) chk(!search_fail, "R3 not yet failed", search_fail, 0);
      if (k == 15) chk(search_fail, "R3 fail on wrap", search_fail, 1);
      if (k < 15) step_n(1);
    end
    fail_clr = 1;
    step_n(1);
    fail_clr = 0;
    chk(!search_fail, "R3 cleared", search_fail, 0);
  endtask

  task automatic t_doppler;
    do_reset(1, 100, 0, 0);
    chk(freq_cmd == 1080, "R2 doppler centre", freq_cmd, 1080);
    do_reset(0, 100, 0, 0);
    chk(freq_cmd == 980, "R2 nominal centre", freq_cmd, 980);
  endtask

  task automatic t_tone_and_resolve;
    do_reset(0, 0, 0, 0);
    tone_lock = 1; step_n(2);
    tone_lock = 0; step_n(1);
    chk(!st_tone_lock, "R4 broken run", st_tone_lock, 0);
    tone_lock = 1; step_n(2);
    chk(!st_tone_lock, "R4 two ticks", st_tone_lock, 0);
    held_f = freq_cmd;
    step_n(1);
    chk(st_tone_lock && !st_code_lock, "R11 tone status", st_tone_lock, 1);
    chk(freq_cmd == held_f, "R4 freq frozen", freq_cmd, held_f);
    chk(!rng_preload, "R6 no aid no preload", rng_preload, 0);
    chk(comp_idx == 0 && bw_sel == 5, "R5 first comp", comp_idx, 0);
    comp_lock = 1;
    step_n(2);
    chk(comp_idx == 0, "R5 comp0 not yet", comp_idx, 0);
    step_n(1);
    chk(comp_idx == 1, "R5 comp1", comp_idx, 1);
    step_n(3);
    chk(comp_idx == 2 && !st_code_lock, "R5 comp2", comp_idx, 2);
    step_n(3);
    chk(st_code_lock && !st_acq, "R11 code lock", st_code_lock, 1);
    chk(bw_sel == 2, "R7 track bw", bw_sel, 2);
    step_n(4);
    chk(freq_cmd == held_f, "R4 freq in track", freq_cmd, held_f);
  endtask

  task automatic t_range;
    timing_pulse = 1; range_in = 32'hA5A5_0123;
    step_n(1);
    chk(range_word == 32'hA5A5_0123 && range_valid, "R10 capture", range_word, 32'hA5A5_0123);
    range_in = 32'h0000_7777;
    step_n(1);
    chk(range_word == 32'hA5A5_0123, "R10 held pulse no recapture", range_word, 32'hA5A5_0123);
    timing_pulse = 0;
    step_n(1);
  endtask

  task automatic t_loss_reacq;
    tone_lock = 0;
    step_n(1);
    chk(st_code_lock && !alarm_loss, "R9 one tick not loss", st_code_lock, 1);
    step_n(1);
    chk(!st_code_lock && alarm_loss, "R9 loss declared", alarm_loss, 1);
    chk(st_odd_even, "R11 parity flip", st_odd_even, 1);
    chk(!range_valid, "R10 valid drops", range_valid, 0);
    chk(freq_cmd == held_f - 20, "R9 reseeded sweep", freq_cmd, held_f - 20);
    tone_lock = 1;
    step_n(3);
    chk(rng_preload && rng_preload_val == 32'hA5A5_0123, "R6 seed preload", rng_preload_val, 32'hA5A5_0123);
    step_n(1);
    chk(!rng_preload && comp_idx == 1, "R6 aided fast comp", comp_idx, 1);
    step_n(2);
    chk(st_code_lock && !alarm_loss, "R9 alarm clears", alarm_loss, 0);
  endtask

  task automatic t_aid_priority;
    do_reset(0, 0, 1, 32'h0BAD_CAFE);
    tone_lock = 1;
    for (int i = 0; i < 10 && !st_tone_lock; i++) step_n(1);
    chk(rng_preload && rng_preload_val == 32'h0BAD_CAFE, "R6 aid preload", rng_preload_val, 32'h0BAD_CAFE);
  endtask

  task automatic t_auto_bw;
    do_reset(0, 0, 0, 0);
    cfg_auto_bw = 1;
    snr_meas = 25; #1;
    chk(bw_sel == 1, "R8 high snr acq", bw_sel, 1);
    snr_meas = 15; #1;
    chk(bw_sel == 2, "R8 mid snr acq", bw_sel, 2);
    snr_meas = 5; #1;
    chk(bw_sel == 3, "R8 low snr acq", bw_sel, 3);
    cfg_auto_bw = 0; #1;
    chk(bw_sel == 5, "R7 manual acq", bw_sel, 5);
  endtask

  initial begin
    rst_n = 0;
    t_reset_state();
    t_sweep_plain();
    t_doppler();
    t_tone_and_resolve();
    t_range();
    t_loss_reacq();
    t_aid_priority();
    t_auto_bw();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule